// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers one non-maskable reset request and a parameterised set of interrupt request lines, ten by default, and hands the CPU a vector address. The vector address selects the program entry for the chosen source. Each source has its own enable bit. A global enable bit, set and cleared by the CPU, gates every source at once. When the global bit is set and at least one enabled request is pending, the block offers the vector of the pending source with the lowest index. Reset takes vector 0, and interrupt source i takes vector i+1.

The vector leaves the block on a valid/ready stream. `vec_valid` means a vector is on offer. The CPU takes it by holding `vec_ready` high for one clock edge while `vec_valid` is high. That edge is the accept. While `vec_ready` is low, nothing is consumed: every flag stays pending and the global enable does not change. The offered address may change while it waits, for example when a higher-priority request arrives or an enable bit changes. The CPU receives whichever address is present on the accept edge.

Accepting an interrupt clears the global enable. The CPU sets it again with `gie_set` when it returns from the handler. Some sources are latched flags, such as edges or timer events. The flag of such a source clears when its vector is accepted. Other sources are level requests, such as a transmit buffer that is empty. A level source follows its input and is never cleared by the block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After `rst_n` is released, the global enable is 0, so `vec_valid` stays 0 even when an enabled request is pending.
- R2: While `rst_req` is high, `vec_valid` is 1 and `vec_addr` is 0, whatever the enables are. Any clock edge with `rst_req` high clears every pending flag and the global enable.
- R3: Source i is offered only when `irq_en[i]` and the global enable are both 1. A latched flag stays pending while its source is masked, and it is offered once the source is unmasked.
- R4: When several enabled sources are pending, the source with the lowest index wins, and `vec_addr` = index + 1. The default order, from index 0 upward, is: external line 0, external line 1, timer1 capture, timer1 compare, timer1 overflow, timer0 overflow, serial receive done, serial transmit-buffer empty, serial transmit done, comparator.
- R5: An accept (`vec_valid` and `vec_ready` both high on a clock edge, with `rst_req` low) clears the global enable. After that edge, `vec_valid` is 0.
- R6: For a source whose bit in `AUTO_CLEAR` is 1, a one-cycle pulse on `irq_in` sets a flag. The accept that serves that source clears the flag. The flags of other sources are left pending.
- R7: A source whose bit in `AUTO_CLEAR` is 0 is a level request. It is pending exactly while its `irq_in` is high, and an accept does not clear it. Index 7 is the level source by default.
- R8: `gie_set` sets the global enable on the next edge. `gie_clr` clears it. When both are high, clear wins.
- R9: A new request pulse on a source in the same cycle as the accept that clears that source is not lost, and the source stays pending.
- R10: While `vec_ready` is low, no flag is cleared and the global enable is not changed by the offered vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Combined reset request (pin, power-on, watchdog); non-maskable |
| irq_in | input | NUM_IRQ | Interrupt request lines; pulses for flag sources, levels for level sources |
| irq_en | input | NUM_IRQ | Per-source enable bits |
| gie_set | input | 1 | Set global enable (return from handler) |
| gie_clr | input | 1 | Clear global enable |
| vec_valid | output | 1 | A vector is offered |
| vec_ready | input | 1 | CPU accepts the offered vector on this edge |
| vec_addr | output | VEC_W | Offered vector address (0 = reset) |

## Verification
The bench builds the block with its defaults: ten sources, a four-bit vector and index 7 as the only level source. With these values the full address range 0 to 10 can be reached, including both ends of the priority order. The bench checks the auto-clear path against the level path on the same accept sequence. It also covers masked-but-latched flags, the collision between a clear and a new pulse, and the global enable clear that overrides a simultaneous set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // default source count and the level-type source mask (bit 7 is level)
  localparam int unsigned DEF_NUM_IRQ = 10;
  localparam logic [DEF_NUM_IRQ-1:0] DEF_AUTO_CLEAR = 10'h37F;

  typedef struct packed {
    logic set;
    logic clr;
  } gie_cmd_t;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int unsigned N = 10,
  parameter logic [N-1:0] AUTO_CLEAR = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (AUTO_CLEAR[i]) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_q[i] <= 1'b0;
        else if (flush) flag_q[i] <= 1'b0;
        else            flag_q[i] <= (flag_q[i] & ~clr[i]) | irq_in[i];
      end
      assign pend[i] = flag_q[i];
    end else begin : g_level
      assign flag_q[i] = 1'b0;
      assign pend[i]   = irq_in[i];
    end
  end

  // latched flags never drop unless cleared by an accept or a reset request
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ((pend & $past(pend & ~clr & AUTO_CLEAR)) == $past(pend & ~clr & AUTO_CLEAR)));

  // a reset request empties every latched flag
  p_flush_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((flag_q & AUTO_CLEAR) == '0));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned N = 10,
  parameter int unsigned VW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [N-1:0]  grant,
  output logic [VW-1:0] addr
);
  always_comb begin
    grant = '0;
    addr  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        addr     = VW'(i + 1);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/irqc_gie.sv
module irqc_gie
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  gie_cmd_t cmd,
  input  logic     accept,
  output logic     gie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           gie <= 1'b0;
    else if (flush || accept || cmd.clr)  gie <= 1'b0;
    else if (cmd.set)                     gie <= 1'b1;
  end

  p_accept_drops_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie);

  p_clr_beats_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.set && cmd.clr) |=> !gie);

  p_set_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.set && !cmd.clr && !accept && !flush) |=> gie);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = DEF_NUM_IRQ,
  parameter logic [NUM_IRQ-1:0] AUTO_CLEAR = DEF_AUTO_CLEAR,
  localparam int unsigned VEC_W = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               gie_set,
  input  logic               gie_clr,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [VEC_W-1:0]   vec_addr
);
  logic [NUM_IRQ-1:0] pend, req, grant, clr;
  logic [VEC_W-1:0]   arb_addr;
  logic               any, gie_q, svc_accept;
  gie_cmd_t           cmd;

  assign cmd.set = gie_set;
  assign cmd.clr = gie_clr;

  irqc_flags #(.N(NUM_IRQ), .AUTO_CLEAR(AUTO_CLEAR)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(rst_req),
    .irq_in(irq_in), .clr(clr), .pend(pend)
  );

  assign req = pend & irq_en & {NUM_IRQ{gie_q}};

  irqc_arbiter #(.N(NUM_IRQ), .VW(VEC_W)) u_arb (
    .req(req), .any(any), .grant(grant), .addr(arb_addr)
  );

  assign vec_valid  = rst_req | any;
  assign vec_addr   = rst_req ? '0 : arb_addr;
  assign svc_accept = vec_valid & vec_ready & ~rst_req;
  assign clr        = svc_accept ? grant : '0;

  irqc_gie u_gie (
    .clk(clk), .rst_n(rst_n), .flush(rst_req),
    .cmd(cmd), .accept(svc_accept), .gie(gie_q)
  );

  // an interrupt vector is only offered under the global enable
  p_masked_by_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !rst_req) |-> gie_q);

  // after a reset request only another reset request can raise valid
  p_reset_quiets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (rst_req || !vec_valid));

  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  // without ready nothing is consumed
  p_no_clear_on_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_ready |-> (clr == '0));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  localparam int N = 10;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic [N-1:0] irq_en = '0;
  logic gie_set = 1'b0, gie_clr = 1'b0, vec_ready = 1'b0;
  logic vec_valid;
  logic [VW-1:0] vec_addr;

  int n_checks = 0;
  int n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_in(irq_in),
    .irq_en(irq_en), .gie_set(gie_set), .gie_clr(gie_clr),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse: flag sources see a one-cycle request
  task automatic pulse(logic [N-1:0] m);
    irq_in = irq_in | m;
    tick();
    irq_in = irq_in & ~m;
  endtask

  task automatic set_gie();
    gie_set = 1'b1;
    tick();
    gie_set = 1'b0;
  endtask

  // driver: push expected vector, raise ready for one edge
  task automatic accept(int exp);
    exp_q.push_back(exp);
    vec_ready = 1'b1;
    tick();
    vec_ready = 1'b0;
  endtask

  // monitor: mid-cycle, a handshake is pending for the next edge
  always @(negedge clk) begin
    if (rst_n && vec_valid && vec_ready) begin
      if (exp_q.size() == 0) check("R4 unexpected accept", int'(vec_addr), -1);
      else check("R4 accepted vector", int'(vec_addr), exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 valid after reset", int'(vec_valid), 0);
    irq_en = '1;
    pulse(10'b00_0000_1000);
    tick();
    check("R1 pending but gie off", int'(vec_valid), 0);

    set_gie();
    check("R8 gie_set offers", int'(vec_valid), 1);
    check("R4 addr of src3", int'(vec_addr), 4);
    repeat (3) tick();
    check("R10 valid held", int'(vec_valid), 1);
    check("R10 addr held", int'(vec_addr), 4);
    accept(4);
    check("R5 gie cleared by accept", int'(vec_valid), 0);

    // priority among 1,5,9 and auto clear
    pulse(10'b10_0010_0010);
    set_gie();
    check("R4 lowest index wins", int'(vec_addr), 2);
    accept(2);
    set_gie();
    check("R6 next pending after clear", int'(vec_addr), 6);
    accept(6);
    set_gie();
    check("R4 comparator vector", int'(vec_addr), 10);
    accept(10);
    set_gie();
    check("R6 all flags cleared", int'(vec_valid), 0);

    // masking keeps the latched flag
    irq_en = 10'b11_1111_1110;
    pulse(10'b01_0000_0001);
    check("R3 masked src0 skipped", int'(vec_addr), 9);
    accept(9);
    irq_en = '1;
    set_gie();
    check("R3 unmasked src0 offered", int'(vec_addr), 1);
    accept(1);

    // level source 7
    irq_in[7] = 1'b1;
    set_gie();
    check("R7 level source offered", int'(vec_addr), 8);
    accept(8);
    set_gie();
    check("R7 level not cleared", int'(vec_addr), 8);
    irq_in[7] = 1'b0;
    tick();
    check("R7 level follows input", int'(vec_valid), 0);

    // clear beats set
    pulse(10'b00_0000_0100);
    gie_set = 1'b1;
    gie_clr = 1'b1;
    tick();
    gie_set = 1'b0;
    gie_clr = 1'b0;
    check("R8 clear wins over set", int'(vec_valid), 0);
    set_gie();
    check("R8 set after clear", int'(vec_addr), 3);
    irq_in[2] = 1'b1;
    accept(3);
    irq_in[2] = 1'b0;
    set_gie();
    check("R9 collided pulse kept", int'(vec_addr), 3);
    accept(3);

    // reset request
    pulse(10'b00_0001_0000);
    set_gie();
    rst_req = 1'b1;
    irq_en = '0;
    #0.5;
    check("R2 reset valid", int'(vec_valid), 1);
    check("R2 reset addr", int'(vec_addr), 0);
    tick();
    rst_req = 1'b0;
    irq_en = '1;
    tick();
    check("R2 gie cleared by reset", int'(vec_valid), 0);
    set_gie();
    check("R2 flags cleared by reset", int'(vec_valid), 0);

    tick();
    check("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule